// File: doc/BRIEF.md
# Manchester Receive Nibble Decoder

The block turns a 10 Mb/s Manchester line into 4-bit receive nibbles. Clock recovery happens upstream. It delivers one recovered half-bit on `sample_i` for each cycle in which `strobe_i` is high, which gives two half-bits per bit. The block takes in nothing on any other cycle.

While the frame flag is low, the block watches the last eight half-bits for the opening preamble. When it finds the opening preamble, it fixes pair alignment, raises `rx_dv_o` and starts to decode pairs into bits. It packs every four bits into a nibble. On each completed nibble it gives a one-cycle `rx_clk_en_o` pulse, which the MAC side uses as its nibble clock enable. `rx_er_o` travels with any nibble that held a coding violation.

A frame ends in one of two ways: a run of zero half-bits, or the four-bit idle terminator. When either is seen, the flag drops and any unfinished nibble is thrown away.

Top module: `mrx_nib_dec`

## Requirements
- R1: After alignment, each pair of half-bits decodes to one bit: the pair 1 then 0 gives logic 1, and the pair 0 then 1 gives logic 0.
- R2: `rx_dv_o` rises in the clock after the strobe whose half-bit completes the window 1,0,0,1,1,0,0,1 (oldest first), which is the four preamble bits 1,0,1,0. The next strobed half-bit is the first half of the first data pair. No other pattern raises `rx_dv_o`.
- R3: Bits fill the nibble least significant bit first, so the first decoded bit lands on `rxd_o[0]`. On every fourth bit, `rxd_o` updates and `rx_clk_en_o` pulses high for exactly one clock. At all other times `rxd_o` holds its value.
- R4: A pair with equal half-bits is a violation and decodes as the value of its first half. The nibble that contains it is presented with `rx_er_o` high, and that `rx_er_o` value holds until the next nibble.
- R5: While `rx_dv_o` is low, `rx_er_o` stays low, whatever the line carries.
- R6: While `rx_dv_o` is high, `ZERO_RUN` (default 8) consecutive strobed zero half-bits clear `rx_dv_o` in the clock after the last one.
- R7: While `rx_dv_o` is high, a window whose last eight half-bits read 1,1,1,1,0,0,0,0 clears `rx_dv_o` in the clock after the last one.
- R8: A strobe that ends the frame produces no nibble, even if it would complete one. A partial nibble is discarded, and `rx_er_o` is cleared when the frame ends.
- R9: Cycles with `strobe_i` low change no output, whatever `sample_i` carries.
- R10: After reset, `rx_dv_o`, `rx_er_o` and `rx_clk_en_o` are low and `rxd_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Half-bit sample strobe |
| sample_i | input | 1 | Recovered half-bit value |
| rxd_o | output | NIB_W | Decoded nibble |
| rx_clk_en_o | output | 1 | One-cycle nibble enable |
| rx_dv_o | output | 1 | Frame data valid |
| rx_er_o | output | 1 | Violation in current nibble |

## Verification
The assertions take two things for granted about the inputs: only strobed cycles carry line information, and a nibble needs at least eight strobes. As a result, nibble pulses can never fall in adjacent clocks, and the frame flag can only move on the cycle after a strobe.

The stimulus places strobes one to three clocks apart and randomizes `sample_i` on every unstrobed cycle. This tests that those values are ignored without breaking either assumption. Frames mix directed and random payloads, injected violations, partial nibbles, both kinds of ending, and noise while the flag is low.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int unsigned WIN_W = 8;
  // four preamble bits 1,0,1,0 as half-bits, oldest in MSB
  localparam logic [WIN_W-1:0] OPEN_PAT  = 8'b1001_1001;
  // idle terminator 11 11 00 00, oldest in MSB
  localparam logic [WIN_W-1:0] CLOSE_PAT = 8'b1111_0000;
endpackage

// File: rtl/mrx_line_mon.sv
module mrx_line_mon
  import mrx_pkg::*;
#(
  parameter int unsigned ZERO_RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic sample_i,
  output logic open_hit_o,
  output logic close_hit_o
);
  localparam int unsigned ZW = $clog2(ZERO_RUN + 1);

  logic [WIN_W-1:0] win_q, win_nx;
  logic [ZW-1:0]    zr_q, zr_nx;

  always_comb begin
    win_nx = {win_q[WIN_W-2:0], sample_i};
    if (sample_i)                  zr_nx = '0;
    else if (zr_q == ZW'(ZERO_RUN)) zr_nx = zr_q;
    else                           zr_nx = zr_q + 1'b1;
  end

  assign open_hit_o  = strobe_i && (win_nx == OPEN_PAT);
  assign close_hit_o = strobe_i && ((win_nx == CLOSE_PAT) || (zr_nx == ZW'(ZERO_RUN)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      zr_q  <= '0;
    end else if (strobe_i) begin
      win_q <= win_nx;
      zr_q  <= zr_nx;
    end
  end

  p_zero_run_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zr_q <= ZW'(ZERO_RUN));
endmodule

// File: rtl/mrx_pair.sv
module mrx_pair (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic sample_i,
  output logic bit_vld_o,
  output logic bit_val_o,
  output logic bit_viol_o
);
  logic phase_q, first_q;

  assign bit_vld_o  = en_i && strobe_i && phase_q;
  assign bit_val_o  = first_q;
  assign bit_viol_o = (first_q == sample_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
    end else if (!en_i) begin
      phase_q <= 1'b0;
    end else if (strobe_i) begin
      phase_q <= ~phase_q;
      if (!phase_q) first_q <= sample_i;
    end
  end

  // alignment restarts on the first half of a pair whenever decoding is off
  p_phase_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !phase_q);
endmodule

// File: rtl/mrx_nibble.sv
module mrx_nibble #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic             bit_viol_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             er_o,
  output logic             en_o
);
  localparam int unsigned CW = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  logic [CW-1:0]    cnt_q;
  logic [NIB_W-1:0] sh_q, sh_nx;
  logic             vacc_q;
  logic             last;

  assign last = (cnt_q == CW'(NIB_W - 1));

  always_comb begin
    sh_nx        = sh_q;
    sh_nx[cnt_q] = bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      vacc_q <= 1'b0;
      rxd_o  <= '0;
      er_o   <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      en_o <= 1'b0;
      if (flush_i) begin
        cnt_q  <= '0;
        vacc_q <= 1'b0;
        er_o   <= 1'b0;
      end else if (bit_vld_i) begin
        if (last) begin
          cnt_q  <= '0;
          vacc_q <= 1'b0;
          rxd_o  <= sh_nx;
          er_o   <= vacc_q | bit_viol_i;
          en_o   <= 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          sh_q   <= sh_nx;
          vacc_q <= vacc_q | bit_viol_i;
        end
      end
    end
  end

  p_en_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> !en_o);
  p_rxd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rxd_o) |-> en_o);
  p_er_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(er_o) |-> (en_o || $past(flush_i)));
endmodule

// File: rtl/mrx_nib_dec.sv
module mrx_nib_dec #(
  parameter int unsigned ZERO_RUN = 8,
  parameter int unsigned NIB_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             sample_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_clk_en_o,
  output logic             rx_dv_o,
  output logic             rx_er_o
);
  logic open_hit, close_hit, dv_q, flush;
  logic bit_vld, bit_val, bit_viol;

  mrx_line_mon #(.ZERO_RUN(ZERO_RUN)) u_mon (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .sample_i    (sample_i),
    .open_hit_o  (open_hit),
    .close_hit_o (close_hit)
  );

  assign flush = dv_q && close_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dv_q <= 1'b0;
    else if (!dv_q && open_hit) dv_q <= 1'b1;
    else if (flush)             dv_q <= 1'b0;
  end

  mrx_pair u_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (dv_q),
    .strobe_i   (strobe_i),
    .sample_i   (sample_i),
    .bit_vld_o  (bit_vld),
    .bit_val_o  (bit_val),
    .bit_viol_o (bit_viol)
  );

  mrx_nibble #(.NIB_W(NIB_W)) u_nib (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .bit_vld_i  (bit_vld),
    .bit_val_i  (bit_val),
    .bit_viol_i (bit_viol),
    .rxd_o      (rxd_o),
    .er_o       (rx_er_o),
    .en_o       (rx_clk_en_o)
  );

  assign rx_dv_o = dv_q;

  p_en_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clk_en_o |-> rx_dv_o);
  p_er_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> rx_dv_o);
  p_dv_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_dv_o) |-> $past(open_hit));
  p_dv_close_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_dv_o) |-> !rx_clk_en_o && !rx_er_o);
  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(strobe_i) |-> ($stable(rx_dv_o) && !rx_clk_en_o));
endmodule

// File: tb/mrx_nib_dec_tb.sv
module mrx_nib_dec_tb;
  localparam int unsigned ZR = 8;
  localparam int unsigned NW = 4;

  logic clk = 1'b0, rst_ni = 1'b0, strobe = 1'b0, sample = 1'b0;
  logic [NW-1:0] rxd;
  logic en, dv, er;
  int total = 0, bad = 0;
  bit finished = 0;
  string cur = "R10";

  always #2.5 clk = ~clk;

  mrx_nib_dec #(.ZERO_RUN(ZR), .NIB_W(NW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .sample_i(sample),
    .rxd_o(rxd), .rx_clk_en_o(en), .rx_dv_o(dv), .rx_er_o(er)
  );

  // reference model built from the requirements
  logic [7:0] m_win = '0;
  int m_zr = 0, m_cnt = 0;
  logic m_dv = 0, m_ph = 0, m_first = 0, m_vacc = 0, m_er = 0, m_en = 0;
  logic [NW-1:0] m_nib = '0, m_rxd = '0;

  function automatic void model_step(logic s);
    logic [7:0] wn;
    int zn;
    wn = {m_win[6:0], s};
    zn = s ? 0 : ((m_zr >= ZR) ? ZR : m_zr + 1);
    m_en = 0;
    if (!m_dv) begin
      if (wn == 8'b1001_1001) begin
        m_dv = 1; m_ph = 0; m_cnt = 0; m_vacc = 0;
      end
    end else if (wn == 8'b1111_0000 || zn >= ZR) begin
      m_dv = 0; m_er = 0; m_cnt = 0; m_vacc = 0;
    end else if (!m_ph) begin
      m_first = s; m_ph = 1;
    end else begin
      m_ph = 0;
      m_nib[m_cnt] = m_first;
      m_vacc = m_vacc | (m_first == s);
      if (m_cnt == NW - 1) begin
        m_rxd = m_nib; m_er = m_vacc; m_en = 1; m_cnt = 0; m_vacc = 0;
      end else m_cnt++;
    end
    m_win = wn; m_zr = zn;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur, what, act, exp);
    end
  endtask

  task automatic cmp_all(input bit quiet);
    chk(dv == m_dv, quiet ? "R9 dv" : "dv", dv, m_dv);
    chk(en == (quiet ? 1'b0 : m_en), quiet ? "R9 en" : "en", en, quiet ? 0 : m_en);
    chk(er == m_er, quiet ? "R9 er" : "er", er, m_er);
    chk(rxd == m_rxd, quiet ? "R9 rxd" : "rxd", rxd, m_rxd);
  endtask

  task automatic hb(input logic s);
    @(negedge clk); strobe = 1'b1; sample = s;
    @(negedge clk); strobe = 1'b0; sample = 1'($urandom);
    model_step(s);
    cmp_all(0);
    repeat ($urandom % 3) begin
      @(negedge clk); sample = 1'($urandom);
      cmp_all(1);
    end
  endtask

  task automatic mbit(input logic b, input bit viol);
    hb(b);
    hb(viol ? b : ~b);
  endtask

  task automatic preamble(input int nbits);
    for (int i = 0; i < nbits; i++) mbit(1'((i + 1) % 2), 0);
  endtask

  task automatic nibble(input logic [NW-1:0] v, input int viol_at);
    for (int i = 0; i < NW; i++) mbit(v[i], i == viol_at);
  endtask

  task automatic term_end;
    hb(1); hb(1); hb(1); hb(1); hb(0); hb(0); hb(0); hb(0);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) hb(0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    cur = "R10";
    chk(dv == 0 && er == 0 && en == 0 && rxd == 0, "reset outputs", {dv, er, en, rxd}, 0);
    rst_ni = 1'b1;
    zeros(12);

    // R2: dv stays low for 3.5 preamble bits, rises on the 8th half-bit
    cur = "R2";
    hb(1); hb(0); hb(0); hb(1); hb(1); hb(0); hb(0);
    chk(dv == 0, "R2 early dv", dv, 0);
    hb(1);
    chk(dv == 1, "R2 open", dv, 1);
    // R1 R3: bits 1,0,0,0 -> 0001; 0,1,1,1 -> 1110
    cur = "R1";
    nibble(4'b0001, -1);
    chk(rxd == 4'b0001, "R1 R3 lsb first", rxd, 1);
    nibble(4'b1110, -1);
    chk(rxd == 4'b1110, "R3 second nibble", rxd, 14);
    // R4: violation in bit 2
    cur = "R4";
    nibble(4'b0110, 2);
    chk(er == 1, "R4 er set", er, 1);
    nibble(4'b1010, -1);
    chk(er == 0, "R4 er next clean", er, 0);
    // R7: terminator completes no nibble (R8)
    cur = "R7";
    term_end;
    chk(dv == 0, "R7 closed", dv, 0);

    // R5: violations and noise with dv low
    cur = "R5";
    for (int i = 0; i < 40; i++) hb((i / 3) % 2 == 0);
    chk(er == 0, "R5 er low", er, 0);
    zeros(10);

    // R6 R8: partial nibble then zero run
    cur = "R6";
    preamble(6);
    nibble(4'b1001, 0);
    mbit(1, 0); mbit(0, 0);
    zeros(ZR);
    chk(dv == 0, "R6 zero run close", dv, 0);
    cur = "R8";
    chk(er == 0, "R8 er cleared", er, 0);

    // random frames
    cur = "R1 R3 R4";
    for (int f = 0; f < 30; f++) begin
      cur = (f % 2) ? "R7" : "R6";
      preamble(4 + 2 * ($urandom % 4));
      for (int k = 0; k < 2 + ($urandom % 6); k++)
        nibble(4'($urandom), ($urandom % 4 == 0) ? int'($urandom % 4) : -1);
      for (int k = 0; k < int'($urandom % 4); k++) mbit(1'($urandom), 0);
      if (f % 2) term_end; else zeros(ZR);
      zeros(2);
      cur = "R8";
      chk(dv == 0, "R8 frame end", dv, 0);
      for (int k = 0; k < int'($urandom % 12); k++) hb(1'($urandom));
      zeros(ZR + 2);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule